// File: doc/BRIEF.md
# External Trigger Clock Conditioner

This block lets a slow or asynchronous trigger waveform advance a counter that runs on a kernel clock. A source multiplexer picks either a dedicated trigger pin or one of fifteen internal trigger lines. The chosen signal can be inverted, so the block counts either rising or falling edges. A toggle divider clocked directly by the corrected signal then divides the edge rate by 1, 2, 4 or 8.

The divider output crosses into the kernel domain through a two-flop synchronizer. An optional majority-free run-length filter follows: a new level must be seen on N consecutive kernel samples before it is accepted. Every change of the filtered divider output is one qualified edge. When external counting is enabled, each qualified edge raises a one-cycle count pulse, and the built-in up-counter advances on that pulse while the counter enable is set.

Because the divider sits ahead of the synchronizer, the corrected input may run faster than the kernel can sample, as long as the divided rate stays within the sampling limit. All configuration arrives on plain input ports.

Top module: `trig_clk_cond`

## Requirements
- R1: `src_sel` = 0 routes `ext_pin`; `src_sel` = k (1..15) routes `int_trig[k]`. Lines that are not selected cause no count.
- R2: With `invert` = 0 the block counts rising edges of the selected line. With `invert` = 1 it counts falling edges, and rising edges cause no count.
- R3: The divider code latched from `psc_code` gives one count per 1, 2, 4 or 8 active edges for codes 0, 1, 2 and 3.
- R4: With filtering off, an active edge applied between kernel clock edges sets `count_pulse` (and updates `count`) after the fourth rising kernel edge that follows it.
- R5: `filt_code` = 0 disables the filter. Codes 1, 2 and 3 need 2, 4 and 8 consecutive samples of a new level, and codes 4..15 need 8. A level change shorter than that yields no count. A change that is accepted adds N-1 cycles to the R4 latency.
- R6: While `ext_mode_en` = 0, `count_pulse` stays low and `count` holds.
- R7: While `cnt_en` = 0, `count_pulse` still fires but `count` holds. With `cnt_en` = 1, each pulse adds exactly one to `count`, modulo 2^CNT_W.
- R8: Each qualified edge produces a `count_pulse` exactly one kernel cycle long.
- R9: A synchronous active-high `rst` clears `count`, `count_pulse`, the synchronizer and the filter. It also clears the divider phase asynchronously, because the divider has no kernel clock.
- R10: `psc_code` is sampled only while `rst` is high. A change made while counting has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset; also clears the divider |
| ext_pin | input | 1 | Dedicated trigger pin (source 0) |
| int_trig | input | 15 | Internal trigger lines, bit k is source k (1..15) |
| src_sel | input | 4 | Trigger source select |
| invert | input | 1 | 1 counts falling edges instead of rising edges |
| psc_code | input | 2 | Divider code: 0=/1, 1=/2, 2=/4, 3=/8 (latched in reset) |
| filt_code | input | 4 | Filter length code |
| ext_mode_en | input | 1 | Enables the trigger-driven count pulse |
| cnt_en | input | 1 | Enables counter advance |
| count_pulse | output | 1 | One-cycle qualified-edge pulse |
| count | output | 16 | Counter value |

## Verification
The assertions rely on two things the inputs must provide. The divided trigger must change no faster than the filter can accept, so two qualified edges are never back to back. `filt_code` must also stay fixed between resets, so a filter length never changes partway through a run. The stimulus holds `filt_code` constant within each reset-delimited phase. Clean edges are spaced eight or more kernel cycles apart, well beyond the longest accepted filter run. The deliberately short glitches are shorter than the active filter length, so they never produce back-to-back filtered changes. The bench drives every input on the falling kernel edge, which makes the synchronizer's sampling deterministic and lets a per-cycle model predict each output exactly.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int PSC_W = 3;
  localparam int RUN_W = 3;

  function automatic logic [3:0] filt_len(input logic [3:0] code);
    case (code)
      4'd0: filt_len = 4'd0;
      4'd1: filt_len = 4'd2;
      4'd2: filt_len = 4'd4;
      default: filt_len = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int NSRC  = 16,
  parameter int SEL_W = $clog2(NSRC)
) (
  input  logic             ext_pin,
  input  logic [NSRC-1:1]  int_trig,
  input  logic [SEL_W-1:0] sel,
  input  logic             invert,
  output logic             pc_out
);
  logic [NSRC-1:0] srcs;

  assign srcs[0] = ext_pin;
  for (genvar g = 1; g < NSRC; g++) begin : g_src
    assign srcs[g] = int_trig[g];
  end

  assign pc_out = srcs[sel] ^ invert;
endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler
  import tcc_pkg::*;
(
  input  logic       pc_in,
  input  logic       clr,
  input  logic [1:0] code,
  output logic       tog
);
  logic [PSC_W-1:0] phase;
  logic [PSC_W-1:0] limit;

  assign limit = (PSC_W'(1) << code) - PSC_W'(1);

  always_ff @(posedge pc_in or posedge clr) begin
    if (clr) begin
      phase <= '0;
      tog   <= 1'b0;
    end else if (phase == limit) begin
      phase <= '0;
      tog   <= ~tog;
    end else begin
      phase <= phase + PSC_W'(1);
    end
  end
endmodule

// File: rtl/trig_sync_filter.sv
module trig_sync_filter
  import tcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tog_in,
  input  logic [3:0] filt_code,
  output logic       filt
);
  logic             s1, s2;
  logic [RUN_W-1:0] run;
  logic [3:0]       n;

  assign n = filt_len(filt_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      run  <= '0;
      filt <= 1'b0;
    end else begin
      s1 <= tog_in;
      s2 <= s1;
      if (n == 4'd0) begin
        filt <= s2;
        run  <= '0;
      end else if (s2 != filt) begin
        if ({1'b0, run} == n - 4'd1) begin
          filt <= s2;
          run  <= '0;
        end else begin
          run <= run + RUN_W'(1);
        end
      end else begin
        run <= '0;
      end
    end
  end

  // R5: with the filter on, an accepted level was seen on at least two prior samples
  assert_filter_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (filt_code != 4'd0 && $past(filt_code) != 4'd0 && filt != $past(filt))
      |-> ($past(s2) == filt && $past(s2, 2) == filt));
endmodule

// File: rtl/trig_clk_cond.sv
module trig_clk_cond #(
  parameter int NSRC  = 16,
  parameter int CNT_W = 16,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pin,
  input  logic [NSRC-1:1]  int_trig,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             invert,
  input  logic [1:0]       psc_code,
  input  logic [3:0]       filt_code,
  input  logic             ext_mode_en,
  input  logic             cnt_en,
  output logic             count_pulse,
  output logic [CNT_W-1:0] count
);
  logic       pc;
  logic       tog;
  logic       filt;
  logic       prev;
  logic [1:0] code_q;

  trig_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .ext_pin (ext_pin),
    .int_trig(int_trig),
    .sel     (src_sel),
    .invert  (invert),
    .pc_out  (pc)
  );

  always_ff @(posedge clk) begin
    if (rst) code_q <= psc_code;
  end

  trig_prescaler u_psc (
    .pc_in(pc),
    .clr  (rst),
    .code (code_q),
    .tog  (tog)
  );

  trig_sync_filter u_sf (
    .clk      (clk),
    .rst      (rst),
    .tog_in   (tog),
    .filt_code(filt_code),
    .filt     (filt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev        <= 1'b0;
      count_pulse <= 1'b0;
      count       <= '0;
    end else begin
      prev        <= filt;
      count_pulse <= (filt != prev) && ext_mode_en;
      if ((filt != prev) && ext_mode_en && cnt_en) count <= count + CNT_W'(1);
    end
  end

  // R8: a pulse lasts exactly one cycle
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    count_pulse |=> !count_pulse);

  // R6: no pulse without the external mode enabled
  assert_pulse_gated_R6: assert property (@(posedge clk) disable iff (rst)
    count_pulse |-> $past(ext_mode_en));

  // R7: the counter moves only by one, only with a pulse and the counter enable
  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |->
      (count_pulse && $past(cnt_en) && count == CNT_W'($past(count) + 1'b1)));

  // R7: a pulse with the counter enabled always advances it
  assert_count_adv_R7: assert property (@(posedge clk) disable iff (rst)
    (count_pulse && $past(cnt_en)) |-> (count != $past(count)));
endmodule

// File: tb/trig_clk_cond_test.sv
module trig_clk_cond_test;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pin = 1'b0;
  logic [15:1] int_trig = '0;
  logic [3:0] src_sel = '0;
  logic invert = 1'b0;
  logic [1:0] psc_code = '0;
  logic [3:0] filt_code = '0;
  logic ext_mode_en = 1'b1;
  logic cnt_en = 1'b1;
  logic count_pulse;
  logic [CNT_W-1:0] count;

  always #4 clk = ~clk;

  trig_clk_cond #(.NSRC(16), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .int_trig(int_trig),
    .src_sel(src_sel), .invert(invert), .psc_code(psc_code),
    .filt_code(filt_code), .ext_mode_en(ext_mode_en), .cnt_en(cnt_en),
    .count_pulse(count_pulse), .count(count)
  );

  int checks = 0;
  int fails = 0;
  int pulses_seen = 0;
  bit done = 0;

  // behavioural reference state
  int m_edges, m_code, m_run;
  bit m_pc, m_tog, m_s1, m_s2, m_f, m_prev, m_pulse;
  int m_count;

  function automatic int need_len(input int c);
    if (c == 0) return 0;
    if (c == 1) return 2;
    if (c == 2) return 4;
    return 8;
  endfunction

  function automatic bit cur_pc();
    bit lvl;
    lvl = (src_sel == 0) ? ext_pin : int_trig[src_sel];
    return lvl ^ invert;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit pc, o_s2, o_f;
    int n;
    pc = cur_pc();
    if (rst) begin
      m_edges = 0; m_tog = 0; m_s1 = 0; m_s2 = 0; m_f = 0; m_run = 0;
      m_prev = 0; m_pulse = 0; m_count = 0; m_code = psc_code; m_pc = pc;
    end else begin
      if (pc && !m_pc) begin
        m_edges++;
        if (m_edges >= (1 << m_code)) begin m_edges = 0; m_tog = !m_tog; end
      end
      m_pc = pc;
      n = need_len(filt_code);
      o_s2 = m_s2; o_f = m_f;
      m_s2 = m_s1; m_s1 = m_tog;
      if (n == 0) m_f = o_s2;
      else if (o_s2 != o_f) begin
        if (m_run == n - 1) begin m_f = o_s2; m_run = 0; end
        else m_run++;
      end else m_run = 0;
      m_pulse = (o_f != m_prev) && ext_mode_en;
      m_prev = o_f;
      if (m_pulse && cnt_en) m_count = (m_count + 1) % (1 << CNT_W);
    end
  endtask

  // one kernel cycle: inputs already set at the falling edge
  task automatic tick();
    model_step();
    @(negedge clk);
    if (count_pulse) pulses_seen++;
    check(count_pulse == m_pulse, "R4/R8 pulse vs model", count_pulse, m_pulse);
    check(count == CNT_W'(m_count), "R7 count vs model", count, m_count);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_line(input bit v);
    if (src_sel == 0) ext_pin = v; else int_trig[src_sel] = v;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ticks(3);
    rst = 1'b0;
    ticks(2);
  endtask

  // n active-high pulses on the selected line
  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      set_line(1); ticks(hi);
      set_line(0); ticks(lo);
    end
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R9: reset state
    check(count == 0 && !count_pulse, "R9 reset state", count, 0);

    // R4 latency with filter off, R8 width
    set_line(1);
    for (int k = 1; k <= 5; k++) begin
      tick();
      check(count_pulse == (k == 4), "R4 latency cycle", count_pulse, (k == 4));
    end
    check(count == 1, "R8 single count", count, 1);
    set_line(0); ticks(4);
    pulses(5, 4, 4); ticks(8);
    check(count == 6, "R1 pin source counts", count, 6);

    // R3 divider codes
    psc_code = 2'd1; do_reset();
    pulses(6, 4, 4); ticks(8);
    check(count == 3, "R3 divide by 2", count, 3);
    psc_code = 2'd2; do_reset();
    pulses(8, 3, 3); ticks(8);
    check(count == 2, "R3 divide by 4", count, 2);
    psc_code = 2'd3; do_reset();
    pulses(16, 2, 2); ticks(8);
    check(count == 2, "R3 divide by 8", count, 2);

    // R2 falling edges
    psc_code = 2'd0; invert = 1'b1; ext_pin = 1'b1; do_reset();
    set_line(0); ticks(8);
    check(count == 1, "R2 falling edge counted", count, 1);
    set_line(1); ticks(8);
    check(count == 1, "R2 rising edge ignored", count, 1);
    pulses(0, 1, 1);
    set_line(0); ticks(6); set_line(1); ticks(6);
    set_line(0); ticks(6); set_line(1); ticks(6);
    check(count == 3, "R2 falling count total", count, 3);
    invert = 1'b0; ext_pin = 1'b0;

    // R1 internal source
    src_sel = 4'd5; do_reset();
    pulses(3, 4, 4); ticks(8);
    check(count == 3, "R1 line 5 counts", count, 3);
    ext_pin = 1; int_trig[4] = 1; ticks(6);
    ext_pin = 0; int_trig[4] = 0; ticks(8);
    check(count == 3, "R1 unselected lines ignored", count, 3);
    src_sel = 4'd0;

    // R5 filter N=4: glitch rejected, clean edge latency 7
    filt_code = 4'd2; do_reset();
    set_line(1); ticks(1); set_line(0); ticks(1); set_line(1); ticks(12);
    check(count == 0, "R5 short glitch rejected", count, 0);
    set_line(0); ticks(6);
    set_line(1);
    for (int k = 1; k <= 8; k++) begin
      tick();
      check(count_pulse == (k == 7), "R5 latency N=4", count_pulse, (k == 7));
    end
    check(count == 1, "R5 clean edge accepted", count, 1);
    set_line(0); ticks(6);

    // R5 code 1 -> N=2 accepts a 3-cycle level
    filt_code = 4'd1; do_reset();
    set_line(1); ticks(1); set_line(0); ticks(2); set_line(1); ticks(12);
    check(count == 2, "R5 N=2 accepts 3 samples", count, 2);
    set_line(0); ticks(4);

    // R5 code 9 saturates to 8
    filt_code = 4'd9; do_reset();
    set_line(1); ticks(1); set_line(0); ticks(5); set_line(1); ticks(16);
    check(count == 0, "R5 N=8 rejects 6 samples", count, 0);
    set_line(0); ticks(6);
    set_line(1);
    for (int k = 1; k <= 12; k++) begin
      tick();
      check(count_pulse == (k == 11), "R5 latency N=8", count_pulse, (k == 11));
    end
    set_line(0); ticks(4);
    filt_code = 4'd0;

    // R6 external mode off
    ext_mode_en = 0; do_reset();
    pulses_seen = 0;
    pulses(3, 4, 4); ticks(8);
    check(count == 0 && pulses_seen == 0, "R6 no pulse or count", pulses_seen, 0);
    ext_mode_en = 1;

    // R7 counter enable off
    cnt_en = 0; do_reset();
    pulses_seen = 0;
    pulses(3, 4, 4); ticks(8);
    check(pulses_seen == 3, "R7 pulses without enable", pulses_seen, 3);
    check(count == 0, "R7 count holds", count, 0);
    cnt_en = 1;

    // R10 divider code latched only in reset
    psc_code = 2'd0; do_reset();
    psc_code = 2'd3;
    pulses(3, 4, 4); ticks(8);
    check(count == 3, "R10 code change ignored", count, 3);
    do_reset();
    pulses(8, 3, 3); ticks(8);
    check(count == 1, "R10 code applied after reset", count, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule